// File: doc/BRIEF.md
# Extended State Save Sequencer

This block turns one processor state-save request into an ordered stream of memory writes into a save area. A pulse on `start_i` captures a base address, a requested-component bitmap, the enabled-component register, a 64-bit-mode flag and an operand-size flag. The block first reads the 64-bit header word of the save area. It then walks each selected state component in a fixed order, pulling register contents through a simple combinational register-file read port. Each piece goes out as one write beat on a 512-bit line bus with byte enables. The last beat rewrites the header with the bits of the components just saved. If the base address is not 64-byte aligned, the block raises a one-cycle fault and touches no memory.

The write bus is line-oriented. The address of each beat is the 64-byte line that holds the field. The payload sits in the byte lanes that match the field's offset inside that line, and the byte enables mark exactly those bytes. Every save-area field fits inside one line, so each field takes exactly one beat.

Top module: `xs_save_seq`

## Requirements
- R1: When `start_i` is sampled with a non-zero `base_i[5:0]` while idle, `fault_o` is high for exactly one cycle. That save issues no header read, no write beat and no `done_o`.
- R2: The saved set is `req_mask_i & en_mask_i`. A component whose bit is clear in that AND produces no beat. Bits 3, 4 and 8 and above are not components.
- R3: Before any write, a single header read is issued at base+512. The final beat writes 8 bytes at base+512 holding the old header OR'ed with the saved-set bits in positions 0, 1, 2, 5, 6 and 7. `done_o` is high for one cycle, in the cycle after that beat is accepted.
- R4: Component bit 0 (legacy floating point) produces three kinds of beat. The environment words go at base+0: 16 bytes holding control word (bytes 0-1), status word (2-3), tag byte (4), zero (5), opcode (6-7) and instruction pointer (8-15). The data pointer goes at base+16 as 8 bytes. Eight stack registers go at base+32+16*i as 16 bytes each: the 80-bit value `rf_data_i[79:0]` followed by six zero bytes.
- R5: The 8-byte control/status beat at base+24, taken from `rf_data_i[63:0]`, is written when bit 1 or bit 2 is saved. It is written once even if both bits are saved.
- R6: Bit 1 saves 16-byte registers at base+160+16*i and bit 2 saves 16-byte upper halves at base+576+16*i. With `long_mode_i` low only i = 0..7 are written; with it high, i = 0..15.
- R7: Bit 5 saves eight 8-byte mask registers at base+1088+8*i. Bit 6 saves sixteen 32-byte values at base+1152+32*i. Bit 7 saves sixteen 64-byte values at base+1664+64*i.
- R8: With `op64_i` high, the instruction and data pointers are stored as 64-bit offsets. With it low, each is stored as a 32-bit offset, then a 16-bit selector, then two zero bytes.
- R9: Beats follow this order: environment, data pointer, stack registers, control/status, bit 1, bit 2, bit 5, bit 6, bit 7, header. Within a component, index i ascends.
- R10: A beat offered on `wr_valid_o` keeps its address, data and enables unchanged until `wr_ready_i` is high. `wr_addr_o` is 64-byte aligned. The payload occupies the byte lanes starting at the field's offset within the line, and `wr_be_o` marks exactly those bytes.
- R11: After reset the block is idle with `busy_o`, `done_o`, `fault_o`, `rd_valid_o` and `wr_valid_o` low. A `start_i` sampled while busy is ignored, and so are input changes made while busy.
- R12: The register-file port presents `rf_comp_o` and `rf_idx_o`, and `rf_data_i` answers in the same cycle. The codes are: 0 environment, 1 data pointer, 2 stack, 3 control/status, 4 bit-1 registers, 5 bit-2 halves, 6 masks, 7 bit-6 values, 8 bit-7 values. For codes 0 and 1 the record fields sit in `rf_data_i` as follows: control [15:0], status [31:16], tag [39:32], opcode [55:40], instruction pointer [119:56], code selector [135:120], data pointer [199:136], data selector [215:200].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a save (sampled when idle) |
| base_i | input | ADDR_W | Save-area base address |
| req_mask_i | input | 8 | Requested components |
| en_mask_i | input | 8 | Enabled components |
| long_mode_i | input | 1 | 64-bit mode: save registers 8-15 |
| op64_i | input | 1 | 64-bit pointer format |
| busy_o | output | 1 | Save in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | One-cycle misalignment fault |
| rd_valid_o | output | 1 | Header read request |
| rd_addr_o | output | ADDR_W | Header read address |
| rd_ready_i | input | 1 | Header read accepted, data valid |
| rd_data_i | input | 64 | Header word |
| rf_comp_o | output | 4 | Register-file component code |
| rf_idx_o | output | 4 | Register-file index |
| rf_data_i | input | 512 | Register-file data (same cycle) |
| wr_valid_o | output | 1 | Write beat valid |
| wr_ready_i | input | 1 | Write beat accepted |
| wr_addr_o | output | ADDR_W | Line-aligned write address |
| wr_data_o | output | 512 | Write data, lane-placed |
| wr_be_o | output | 64 | Byte enables |

## Verification
The header read request appears one cycle after `start_i` is sampled, and `fault_o` appears in that same cycle. Each write beat becomes valid two cycles after the previous handshake (or after the header read handshake): one cycle to format, one to present. `done_o` rises exactly one cycle after the header beat is accepted. The bench drives the ready inputs and records every handshake on the falling edge, because a beat that is valid and ready there is accepted at the next rising edge. It then checks the recorded beats against a list built from the requirements, and checks that the done pulse falls one cycle after the last recorded acceptance.

// File: rtl/xs_pkg.sv
package xs_pkg;
  localparam int LINE_BYTES = 64;
  localparam int DATA_W     = LINE_BYTES * 8;
  localparam int HDR_W      = 64;
  localparam int NUM_STEPS  = 10;
  localparam int OFF_W      = 12;

  // component base offsets inside the save area
  localparam int OFF_ENV  = 0;
  localparam int OFF_DPTR = 16;
  localparam int OFF_CSR  = 24;
  localparam int OFF_STK  = 32;
  localparam int OFF_XMM  = 160;
  localparam int OFF_HDR  = 512;
  localparam int OFF_YMMH = 576;
  localparam int OFF_KMSK = 1088;
  localparam int OFF_ZHI  = 1152;
  localparam int OFF_HIZ  = 1664;

  // header bits that name real components
  localparam logic [7:0] COMP_BITS = 8'hE7;

  typedef enum logic [3:0] {
    ST_ENV  = 4'd0,
    ST_DPTR = 4'd1,
    ST_STK  = 4'd2,
    ST_CSR  = 4'd3,
    ST_XMM  = 4'd4,
    ST_YMMH = 4'd5,
    ST_KMSK = 4'd6,
    ST_ZHI  = 4'd7,
    ST_HIZ  = 4'd8,
    ST_HDR  = 4'd9
  } step_e;

  typedef enum logic [1:0] {
    F_IDLE = 2'd0,
    F_HRD  = 2'd1,
    F_PREP = 2'd2,
    F_WR   = 2'd3
  } fsm_e;

  typedef struct packed {
    logic [15:0] dsel;
    logic [63:0] dptr;
    logic [15:0] csel;
    logic [63:0] iptr;
    logic [15:0] opc;
    logic [7:0]  tag;
    logic [15:0] stat;
    logic [15:0] ctrl;
  } fp_env_t;
endpackage

// File: rtl/xs_plan.sv
module xs_plan
  import xs_pkg::*;
(
  input  logic [7:0] sel_i,
  input  logic       long_i,
  input  step_e      cur_i,
  output step_e      first_o,
  output step_e      next_o,
  output logic [4:0] count_o
);
  logic [NUM_STEPS-1:0] en_vec;

  always_comb begin
    en_vec = '0;
    en_vec[ST_ENV]  = sel_i[0];
    en_vec[ST_DPTR] = sel_i[0];
    en_vec[ST_STK]  = sel_i[0];
    en_vec[ST_CSR]  = sel_i[1] | sel_i[2];
    en_vec[ST_XMM]  = sel_i[1];
    en_vec[ST_YMMH] = sel_i[2];
    en_vec[ST_KMSK] = sel_i[5];
    en_vec[ST_ZHI]  = sel_i[6];
    en_vec[ST_HIZ]  = sel_i[7];
    en_vec[ST_HDR]  = 1'b1;
  end

  // lowest enabled step overall, and lowest enabled step above the current one
  always_comb begin
    first_o = ST_HDR;
    next_o  = ST_HDR;
    for (int k = NUM_STEPS - 1; k >= 0; k--) begin
      if (en_vec[k]) first_o = step_e'(k[3:0]);
      if (en_vec[k] && (k > int'(cur_i))) next_o = step_e'(k[3:0]);
    end
  end

  always_comb begin
    case (cur_i)
      ST_STK, ST_KMSK:  count_o = 5'd8;
      ST_XMM, ST_YMMH:  count_o = long_i ? 5'd16 : 5'd8;
      ST_ZHI, ST_HIZ:   count_o = 5'd16;
      default:          count_o = 5'd1;
    endcase
  end
endmodule

// File: rtl/xs_beat.sv
module xs_beat
  import xs_pkg::*;
(
  input  step_e              step_i,
  input  logic [3:0]         idx_i,
  input  logic [DATA_W-1:0]  rf_i,
  input  logic               op64_i,
  input  logic [HDR_W-1:0]   hdr_i,
  input  logic [7:0]         sel_i,
  output logic [OFF_W-1:0]   line_off_o,
  output logic [DATA_W-1:0]  data_o,
  output logic [LINE_BYTES-1:0] be_o
);
  fp_env_t            env;
  logic [OFF_W-1:0]   off;
  logic [6:0]         len;
  logic [DATA_W-1:0]  pl;
  logic [5:0]         lane;
  logic [LINE_BYTES-1:0] lmask;
  logic [OFF_W-1:0]   ix;

  assign env = fp_env_t'(rf_i[$bits(fp_env_t)-1:0]);
  assign ix  = {{(OFF_W-4){1'b0}}, idx_i};

  always_comb begin
    pl  = '0;
    off = '0;
    len = 7'd8;
    case (step_i)
      ST_ENV: begin
        off = OFF_W'(OFF_ENV);
        len = 7'd16;
        pl[127:0] = {(op64_i ? env.iptr : {16'h0, env.csel, env.iptr[31:0]}),
                     env.opc, 8'h00, env.tag, env.stat, env.ctrl};
      end
      ST_DPTR: begin
        off = OFF_W'(OFF_DPTR);
        pl[63:0] = op64_i ? env.dptr : {16'h0, env.dsel, env.dptr[31:0]};
      end
      ST_STK: begin
        off = OFF_W'(OFF_STK) + (ix << 4);
        len = 7'd16;
        pl[79:0] = rf_i[79:0];
      end
      ST_CSR: begin
        off = OFF_W'(OFF_CSR);
        pl[63:0] = rf_i[63:0];
      end
      ST_XMM: begin
        off = OFF_W'(OFF_XMM) + (ix << 4);
        len = 7'd16;
        pl[127:0] = rf_i[127:0];
      end
      ST_YMMH: begin
        off = OFF_W'(OFF_YMMH) + (ix << 4);
        len = 7'd16;
        pl[127:0] = rf_i[127:0];
      end
      ST_KMSK: begin
        off = OFF_W'(OFF_KMSK) + (ix << 3);
        pl[63:0] = rf_i[63:0];
      end
      ST_ZHI: begin
        off = OFF_W'(OFF_ZHI) + (ix << 5);
        len = 7'd32;
        pl[255:0] = rf_i[255:0];
      end
      ST_HIZ: begin
        off = OFF_W'(OFF_HIZ) + (ix << 6);
        len = 7'd64;
        pl = rf_i;
      end
      default: begin
        off = OFF_W'(OFF_HDR);
        pl[63:0] = hdr_i | {56'h0, sel_i & COMP_BITS};
      end
    endcase
  end

  assign lane       = off[5:0];
  assign lmask      = (len == 7'd64) ? '1 : ((64'd1 << len) - 64'd1);
  assign line_off_o = {off[OFF_W-1:6], 6'b0};
  assign data_o     = pl << {lane, 3'b000};
  assign be_o       = lmask << lane;
endmodule

// File: rtl/xs_save_seq.sv
module xs_save_seq
  import xs_pkg::*;
#(
  parameter int ADDR_W = 48
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_i,
  input  logic [ADDR_W-1:0]      base_i,
  input  logic [7:0]             req_mask_i,
  input  logic [7:0]             en_mask_i,
  input  logic                   long_mode_i,
  input  logic                   op64_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   fault_o,
  output logic                   rd_valid_o,
  output logic [ADDR_W-1:0]      rd_addr_o,
  input  logic                   rd_ready_i,
  input  logic [63:0]            rd_data_i,
  output logic [3:0]             rf_comp_o,
  output logic [3:0]             rf_idx_o,
  input  logic [511:0]           rf_data_i,
  output logic                   wr_valid_o,
  input  logic                   wr_ready_i,
  output logic [ADDR_W-1:0]      wr_addr_o,
  output logic [511:0]           wr_data_o,
  output logic [63:0]            wr_be_o
);
  localparam logic [ADDR_W-1:0] HDR_ADDR_OFF = ADDR_W'(OFF_HDR);

  fsm_e               st;
  step_e              step;
  logic [3:0]         idx;
  logic [ADDR_W-1:0]  base_q;
  logic [7:0]         sel_q;
  logic               long_q;
  logic               op64_q;
  logic [HDR_W-1:0]   hdr_q;

  step_e              first_step;
  step_e              next_step;
  logic [4:0]         step_cnt;
  logic [OFF_W-1:0]   line_off;
  logic [DATA_W-1:0]  beat_data;
  logic [LINE_BYTES-1:0] beat_be;
  logic               last_idx;

  xs_plan u_plan (
    .sel_i   (sel_q),
    .long_i  (long_q),
    .cur_i   (step),
    .first_o (first_step),
    .next_o  (next_step),
    .count_o (step_cnt)
  );

  xs_beat u_beat (
    .step_i     (step),
    .idx_i      (idx),
    .rf_i       (rf_data_i),
    .op64_i     (op64_q),
    .hdr_i      (hdr_q),
    .sel_i      (sel_q),
    .line_off_o (line_off),
    .data_o     (beat_data),
    .be_o       (beat_be)
  );

  assign last_idx  = ({1'b0, idx} == (step_cnt - 5'd1));
  assign busy_o    = (st != F_IDLE);
  assign rf_comp_o = step;
  assign rf_idx_o  = idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= F_IDLE;
      step       <= ST_HDR;
      idx        <= '0;
      base_q     <= '0;
      sel_q      <= '0;
      long_q     <= 1'b0;
      op64_q     <= 1'b0;
      hdr_q      <= '0;
      done_o     <= 1'b0;
      fault_o    <= 1'b0;
      rd_valid_o <= 1'b0;
      rd_addr_o  <= '0;
      wr_valid_o <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
      wr_be_o    <= '0;
    end else begin
      done_o  <= 1'b0;
      fault_o <= 1'b0;
      case (st)
        F_IDLE: begin
          if (start_i) begin
            base_q <= base_i;
            sel_q  <= req_mask_i & en_mask_i;
            long_q <= long_mode_i;
            op64_q <= op64_i;
            if (|base_i[5:0]) begin
              fault_o <= 1'b1;
            end else begin
              rd_valid_o <= 1'b1;
              rd_addr_o  <= base_i + HDR_ADDR_OFF;
              st         <= F_HRD;
            end
          end
        end
        F_HRD: begin
          if (rd_ready_i) begin
            rd_valid_o <= 1'b0;
            hdr_q      <= rd_data_i;
            step       <= first_step;
            idx        <= '0;
            st         <= F_PREP;
          end
        end
        F_PREP: begin
          wr_valid_o <= 1'b1;
          wr_addr_o  <= base_q + {{(ADDR_W-OFF_W){1'b0}}, line_off};
          wr_data_o  <= beat_data;
          wr_be_o    <= beat_be;
          st         <= F_WR;
        end
        default: begin
          if (wr_ready_i) begin
            wr_valid_o <= 1'b0;
            if (step == ST_HDR) begin
              done_o <= 1'b1;
              st     <= F_IDLE;
            end else if (last_idx) begin
              step <= next_step;
              idx  <= '0;
              st   <= F_PREP;
            end else begin
              idx <= idx + 4'd1;
              st  <= F_PREP;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/xs_save_seq_chk.sv
module xs_save_seq_chk #(
  parameter int ADDR_W = 48
) (
  input logic              clk,
  input logic              rst,
  input logic              busy_o,
  input logic              done_o,
  input logic              fault_o,
  input logic              rd_valid_o,
  input logic              rd_ready_i,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              wr_valid_o,
  input logic              wr_ready_i,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [511:0]      wr_data_o,
  input logic [63:0]       wr_be_o
);
  // R10
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o)
      && $stable(wr_data_o) && $stable(wr_be_o));

  // R10
  wr_line_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid_o |-> (wr_addr_o[5:0] == 6'd0) && (wr_be_o != 64'd0));

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_addr_o));

  // R3
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_valid_o && wr_valid_o));

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R1
  fault_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> !busy_o && !rd_valid_o && !wr_valid_o && !done_o);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !rd_valid_o && !wr_valid_o);
endmodule

bind xs_save_seq xs_save_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .fault_o    (fault_o),
  .rd_valid_o (rd_valid_o),
  .rd_ready_i (rd_ready_i),
  .rd_addr_o  (rd_addr_o),
  .wr_valid_o (wr_valid_o),
  .wr_ready_i (wr_ready_i),
  .wr_addr_o  (wr_addr_o),
  .wr_data_o  (wr_data_o),
  .wr_be_o    (wr_be_o)
);

// File: tb/xs_save_seq_test.sv
module xs_save_seq_test;
  import xs_pkg::*;

  localparam int AW = 48;
  localparam int MAXB = 128;
  localparam fp_env_t ENV = '{dsel: 16'h00D5, dptr: 64'h1122_3344_5566_7788,
                              csel: 16'h00C3, iptr: 64'h99AA_BBCC_DDEE_FF01,
                              opc: 16'h07AB, tag: 8'hE1, stat: 16'h3A00, ctrl: 16'h037F};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [AW-1:0] base = '0;
  logic [7:0] req = '0, en = '0;
  logic lng = 1'b0, o64 = 1'b0;
  logic busy, done, fault, rd_valid, wr_valid;
  logic rd_ready = 1'b0;
  logic wr_ready = 1'b0;
  logic [63:0] rd_data = '0;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [3:0] rf_comp, rf_idx;
  logic [511:0] rf_data, wr_data;
  logic [63:0] wr_be;

  int checks = 0, errors = 0, cyc = 0;
  logic [63:0] hdr_mem = '0;
  logic stall = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  logic [AW-1:0]  got_addr [MAXB];
  logic [511:0]   got_data [MAXB];
  logic [63:0]    got_be   [MAXB];
  logic [AW-1:0]  exp_addr [MAXB];
  logic [511:0]   exp_data [MAXB];
  logic [63:0]    exp_be   [MAXB];
  int got_n, exp_n, rd_n, rd_wr_n, done_n, fault_n, done_cyc, last_acc;
  logic [AW-1:0] got_rd_addr;

  always #4 clk = ~clk;

  xs_save_seq #(.ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .start_i(start), .base_i(base), .req_mask_i(req),
    .en_mask_i(en), .long_mode_i(lng), .op64_i(o64), .busy_o(busy),
    .done_o(done), .fault_o(fault), .rd_valid_o(rd_valid), .rd_addr_o(rd_addr),
    .rd_ready_i(rd_ready), .rd_data_i(rd_data), .rf_comp_o(rf_comp),
    .rf_idx_o(rf_idx), .rf_data_i(rf_data), .wr_valid_o(wr_valid),
    .wr_ready_i(wr_ready), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_be_o(wr_be)
  );

  function automatic logic [511:0] rf_val(logic [3:0] c, logic [3:0] i);
    logic [511:0] r;
    if (c <= 4'd1) return {296'h0, ENV};
    for (int k = 0; k < 8; k++) r[k*64 +: 64] = {c, i, 8'(k), 48'h9E37_79B9_7F4A};
    return r;
  endfunction

  assign rf_data = rf_val(rf_comp, rf_idx);

  // bus responder and logger, all on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (done) begin done_n++; done_cyc = cyc; end
    if (fault) fault_n++;
    if (rd_valid && !rd_ready) begin
      rd_ready = 1'b1; rd_data = hdr_mem; rd_n++; got_rd_addr = rd_addr; rd_wr_n = got_n;
    end else begin
      rd_ready = 1'b0;
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    wr_ready = stall ? lfsr[0] : 1'b1;
    if (wr_valid && wr_ready && got_n < MAXB) begin
      got_addr[got_n] = wr_addr; got_data[got_n] = wr_data; got_be[got_n] = wr_be;
      got_n++; last_acc = cyc;
    end
  end

  initial begin
    #1_200_000;
    errors++;
    $display("FAIL watchdog act timeout exp completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(logic ok, string req_s, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act %h exp %h", req_s, act, exp);
    end
  endtask

  task automatic push(int off, logic [511:0] pl, int len);
    int lane = off % 64;
    exp_addr[exp_n] = base + AW'(off - lane);
    exp_data[exp_n] = pl << (lane * 8);
    exp_be[exp_n]   = (len == 64) ? '1 : (((64'd1 << len) - 64'd1) << lane);
    exp_n++;
  endtask

  task automatic build(logic [7:0] sm);
    logic [511:0] r;
    logic [63:0] f;
    exp_n = 0;
    if (sm[0]) begin
      f = o64 ? ENV.iptr : {16'h0, ENV.csel, ENV.iptr[31:0]};
      push(0, {384'h0, f, ENV.opc, 8'h00, ENV.tag, ENV.stat, ENV.ctrl}, 16);
      f = o64 ? ENV.dptr : {16'h0, ENV.dsel, ENV.dptr[31:0]};
      push(16, {448'h0, f}, 8);
      for (int i = 0; i < 8; i++) begin
        r = rf_val(4'd2, 4'(i)); push(32 + 16*i, {432'h0, r[79:0]}, 16);
      end
    end
    if (sm[1] || sm[2]) begin r = rf_val(4'd3, 4'd0); push(24, {448'h0, r[63:0]}, 8); end
    if (sm[1]) for (int i = 0; i < (lng ? 16 : 8); i++) begin
      r = rf_val(4'd4, 4'(i)); push(160 + 16*i, {384'h0, r[127:0]}, 16);
    end
    if (sm[2]) for (int i = 0; i < (lng ? 16 : 8); i++) begin
      r = rf_val(4'd5, 4'(i)); push(576 + 16*i, {384'h0, r[127:0]}, 16);
    end
    if (sm[5]) for (int i = 0; i < 8; i++) begin
      r = rf_val(4'd6, 4'(i)); push(1088 + 8*i, {448'h0, r[63:0]}, 8);
    end
    if (sm[6]) for (int i = 0; i < 16; i++) begin
      r = rf_val(4'd7, 4'(i)); push(1152 + 32*i, {256'h0, r[255:0]}, 32);
    end
    if (sm[7]) for (int i = 0; i < 16; i++) push(1664 + 64*i, rf_val(4'd8, 4'(i)), 64);
    push(512, {448'h0, hdr_mem | {56'h0, sm & 8'hE7}}, 8);
  endtask

  task automatic run(logic [AW-1:0] b, logic [7:0] rq, logic [7:0] en_v, logic l,
                     logic o, logic [63:0] h, logic st_on, logic poke);
    @(negedge clk);
    got_n = 0; rd_n = 0; rd_wr_n = -1; done_n = 0; fault_n = 0; done_cyc = 0; last_acc = 0;
    base = b; req = rq; en = en_v; lng = l; o64 = o; hdr_mem = h; stall = st_on;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (20) @(negedge clk);
      base = b + AW'(8); req = 8'h00; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int t = 0; t < 5000 && done_n == 0 && fault_n == 0; t++) @(negedge clk);
    repeat (4) @(negedge clk);
    base = b; req = rq; lng = l; o64 = o;
  endtask

  task automatic cmp_beats(string req_s);
    chk(got_n == exp_n, {req_s, " beat count"}, 512'(got_n), 512'(exp_n));
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      chk(got_addr[i] == exp_addr[i], {req_s, " addr"}, 512'(got_addr[i]), 512'(exp_addr[i]));
      chk(got_be[i] == exp_be[i], {req_s, " be"}, 512'(got_be[i]), 512'(exp_be[i]));
      chk(got_data[i] == exp_data[i], {req_s, " data"}, got_data[i], exp_data[i]);
    end
  endtask

  task automatic check_end(logic [AW-1:0] b);
    chk(rd_n == 1, "R3 one header read", 512'(rd_n), 512'd1);
    chk(got_rd_addr == b + AW'(512), "R3 header read address", 512'(got_rd_addr), 512'(b + AW'(512)));
    chk(rd_wr_n == 0, "R3 read before writes", 512'(rd_wr_n), 512'd0);
    chk(done_n == 1, "R3 done pulse count", 512'(done_n), 512'd1);
    chk(done_cyc == last_acc + 1, "R3 done timing", 512'(done_cyc), 512'(last_acc + 1));
    chk(fault_n == 0, "R11 no fault", 512'(fault_n), 512'd0);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !fault, "R11 reset flags", {509'h0, busy, done, fault}, 512'h0);
    chk(!rd_valid && !wr_valid, "R11 reset valids", {510'h0, rd_valid, wr_valid}, 512'h0);
  endtask

  task automatic t_full();
    run(48'h10000, 8'hFF, 8'hE7, 1'b1, 1'b1, 64'hF0F0_0000_0000_0A00, 1'b0, 1'b0);
    build(8'hE7);
    cmp_beats("R9 R4 R7 R12 full save");
    check_end(48'h10000);
  endtask

  task automatic t_misaligned();
    run(48'h10020, 8'hFF, 8'hFF, 1'b1, 1'b1, 64'h0, 1'b0, 1'b0);
    chk(fault_n == 1, "R1 fault pulse", 512'(fault_n), 512'd1);
    chk(got_n == 0, "R1 no writes", 512'(got_n), 512'd0);
    chk(rd_n == 0, "R1 no header read", 512'(rd_n), 512'd0);
    chk(done_n == 0, "R1 no done", 512'(done_n), 512'd0);
  endtask

  task automatic t_legacy_stall_poke();
    run(48'h2_4000, 8'h06, 8'hFF, 1'b0, 1'b0, 64'h3, 1'b1, 1'b1);
    build(8'h06);
    cmp_beats("R5 R6 R10 R11 stall 32-bit mode");
    check_end(48'h2_4000);
  endtask

  task automatic t_upper_only();
    run(48'h3_0040, 8'h04, 8'h07, 1'b1, 1'b0, 64'h0, 1'b0, 1'b0);
    build(8'h04);
    cmp_beats("R5 R6 upper halves only");
    check_end(48'h3_0040);
  endtask

  task automatic t_fp32();
    run(48'h4_0000, 8'h01, 8'hFF, 1'b1, 1'b0, 64'h0000_0001_0000_0080, 1'b1, 1'b0);
    build(8'h01);
    cmp_beats("R8 R4 32-bit pointers");
    check_end(48'h4_0000);
  endtask

  task automatic t_and_mask();
    run(48'h5_0000, 8'hE0, 8'hA1, 1'b1, 1'b1, 64'h4, 1'b0, 1'b0);
    build(8'hA0);
    cmp_beats("R2 R7 request and enable");
    check_end(48'h5_0000);
  endtask

  initial begin
    got_n = 0; exp_n = 0; rd_n = 0; done_n = 0; fault_n = 0;
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_full();
    t_misaligned();
    t_legacy_stall_poke();
    t_upper_only();
    t_fp32();
    t_and_mask();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule